// File: doc/BRIEF.md
# Spreading Code Slew Controller

This block sets the phase of a repeating spreading code and can hold that phase back by a programmed amount. A chip counter advances once for every two half-chip ticks. When the count wraps from the last chip of the code back to chip 1, the block raises a one-cycle epoch pulse. A host writes an 11-bit slew value, counted in half chips, into a pending register. When the arming event comes, that value moves into a stall counter. While the stall counter is nonzero, each half-chip tick decrements it and leaves the chip index where it is. The result is that the code phase falls back by the programmed number of half chips, and the epoch that contains the stall is longer by the same amount.

There are two arming modes. In epoch-armed mode, the pending value is taken on the same tick that wraps the code and raises the epoch pulse. In strobe-armed mode, it is taken when an external timing strobe arrives. Once a value has been taken, the pending register is cleared. The primary code is 1023 chips long. A second code-length setting gives a 511-chip code.

The stall counter is never reduced modulo the code length, so wrap behaviour falls out of the counting itself. A value of 2047 gives the same final phase as a value of 1, and the epoch pulse arrives one full code period later. With the short code, the equivalent points are 1023 and 2045.

Top module: `code_slew_ctrl`

## Requirements
- R1: After synchronous reset, chip_idx is 1, dump is 0 and slew_busy is 0.
- R2: With no slew pending, chip_idx advances by one every second cycle in which half_tick is 1 and holds while half_tick is 0. An epoch with the long code lasts 2046 ticks. dump is high for one cycle, in the first cycle that shows chip_idx = 1 after the wrap from 1023.
- R3: With preset_mode = 0 (epoch-armed), a pending slew of 4 is taken on the wrap tick. chip_idx then shows 1 for 6 ticks, and the next dump comes 2050 ticks after the arming dump, which is 1025 chips.
- R4: With preset_mode = 1 (strobe-armed), a pulse on tic moves the pending value into the stall counter at that clock edge, and slew_busy is high in the next cycle. A value of 3 makes the epoch that contains the strobe 2049 ticks long.
- R5: tic has no effect when preset_mode = 0, and a wrap does not arm a slew when preset_mode = 1.
- R6: When wr_en pulses more than once before the arming event, only the last written value is applied.
- R7: A slew value is used once. The epoch after a slewed one lasts 2046 ticks unless the host writes again.
- R8: A value of 2047 stretches the affected long-code epoch to 2046 + 2047 = 4093 ticks.
- R9: With alt_code = 1 the code is 511 chips long, so an epoch lasts 1022 ticks. A value of 1023 stretches the affected epoch to 2045 ticks.
- R10: slew_busy is high for exactly as many ticks as the value that was taken.
- R11: A write while slew_busy is high loads wr_data straight into the running stall counter and leaves the pending register unchanged. Tic → write → stall: a strobe that loads 10, followed by a write of 20 on the next clock edge, gives 21 stalled ticks, so the epoch is 2067 ticks long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | Half-chip advance enable |
| preset_mode | input | 1 | 0: arm on epoch wrap, 1: arm on tic |
| alt_code | input | 1 | 0: 1023-chip code, 1: 511-chip code |
| tic | input | 1 | External timing strobe |
| wr_en | input | 1 | Host write strobe for the slew value |
| wr_data | input | 11 | Slew value in half chips |
| chip_idx | output | 10 | Current chip index, from 1 to the code length |
| dump | output | 1 | One-cycle epoch pulse at the wrap to chip 1 |
| slew_busy | output | 1 | High while the stall counter is nonzero |

## Verification
A wrong stall count appears as an epoch interval that differs from 2046 (or 1022) plus the taken value. It is visible at the very next dump after arming, and slew_busy shows the same error as soon as the stall ends. A pending value that is not cleared shows up as a stretched interval one epoch later. Arming on the wrong event shows up either as slew_busy rising one cycle after a tic that should have been ignored, or as an unexpected stretch at the next dump.

// File: rtl/code_slew_pkg.sv
package code_slew_pkg;

    localparam int SLEW_W_DEF  = 11;
    localparam int CHIP_W_DEF  = 10;
    localparam int PRI_LEN_DEF = 1023;
    localparam int ALT_LEN_DEF = 511;

    typedef enum logic {
        ARM_ON_WRAP   = 1'b0,
        ARM_ON_STROBE = 1'b1
    } arm_mode_e;

    function automatic int sel_len(input logic alt, input int pri_len, input int alt_len);
        return alt ? alt_len : pri_len;
    endfunction

endpackage

// File: rtl/slew_pending.sv
module slew_pending #(
    parameter int SLEW_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLEW_W-1:0] wr_data,
    input  logic              arm,
    input  logic              busy,
    output logic [SLEW_W-1:0] take_val
);
    logic [SLEW_W-1:0] pending;

    // A write in the arming cycle is the latest value, so it wins.
    assign take_val = wr_en ? wr_data : pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
        end else if (arm) begin
            pending <= '0;
        end else if (wr_en && !busy) begin
            pending <= wr_data;
        end
    end

    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (rst)
        arm |=> pending == '0); // R7

endmodule

// File: rtl/slew_stall.sv
module slew_stall #(
    parameter int SLEW_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [SLEW_W-1:0] load_val,
    input  logic              reload,
    input  logic [SLEW_W-1:0] reload_val,
    output logic              busy,
    output logic              hold
);
    logic [SLEW_W-1:0] cnt;

    assign busy = (cnt != '0);
    assign hold = tick && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (reload) begin
            cnt <= reload_val;
        end else if (hold) begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_STALL_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && tick && !load && !reload) |=> cnt == $past(cnt) - 1'b1); // R10

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load && !reload) |=> !busy); // R10

endmodule

// File: rtl/code_phase.sv
module code_phase
    import code_slew_pkg::*;
#(
    parameter int CHIP_W  = 10,
    parameter int PRI_LEN = 1023,
    parameter int ALT_LEN = 511
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              hold,
    input  logic              alt,
    output logic [CHIP_W-1:0] chip,
    output logic              wrap_ev,
    output logic              dump
);
    typedef struct packed {
        logic [CHIP_W-1:0] idx;
        logic              half;
    } phase_t;

    phase_t            ph;
    logic [CHIP_W-1:0] len;
    logic              step;

    assign len     = CHIP_W'(sel_len(alt, PRI_LEN, ALT_LEN));
    assign step    = tick && !hold;
    assign wrap_ev = step && ph.half && (ph.idx >= len);
    assign chip    = ph.idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph.idx  <= CHIP_W'(1);
            ph.half <= 1'b0;
            dump    <= 1'b0;
        end else begin
            dump <= wrap_ev;
            if (step) begin
                ph.half <= !ph.half;
                if (ph.half) begin
                    ph.idx <= wrap_ev ? CHIP_W'(1) : ph.idx + 1'b1;
                end
            end
        end
    end

    AST_CHIP_RANGE: assert property (@(posedge clk) disable iff (rst)
        (ph.idx >= CHIP_W'(1)) && (ph.idx <= CHIP_W'(PRI_LEN))); // R2

    AST_DUMP_FIRST_CHIP: assert property (@(posedge clk) disable iff (rst)
        dump |-> (ph.idx == CHIP_W'(1)) && !ph.half); // R2

    AST_DUMP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        dump |=> !dump); // R2

endmodule

// File: rtl/code_slew_ctrl.sv
module code_slew_ctrl
    import code_slew_pkg::*;
#(
    parameter int SLEW_W  = SLEW_W_DEF,
    parameter int CHIP_W  = CHIP_W_DEF,
    parameter int PRI_LEN = PRI_LEN_DEF,
    parameter int ALT_LEN = ALT_LEN_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_tick,
    input  logic              preset_mode,
    input  logic              alt_code,
    input  logic              tic,
    input  logic              wr_en,
    input  logic [SLEW_W-1:0] wr_data,
    output logic [CHIP_W-1:0] chip_idx,
    output logic              dump,
    output logic              slew_busy
);
    arm_mode_e         mode;
    logic              arm;
    logic              wrap_ev;
    logic              hold;
    logic              reload;
    logic [SLEW_W-1:0] take_val;

    assign mode   = arm_mode_e'(preset_mode);
    assign arm    = (mode == ARM_ON_STROBE) ? tic : wrap_ev;
    assign reload = wr_en && slew_busy && !arm;

    slew_pending #(.SLEW_W(SLEW_W)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .arm      (arm),
        .busy     (slew_busy),
        .take_val (take_val)
    );

    slew_stall #(.SLEW_W(SLEW_W)) u_stall (
        .clk        (clk),
        .rst        (rst),
        .tick       (half_tick),
        .load       (arm),
        .load_val   (take_val),
        .reload     (reload),
        .reload_val (wr_data),
        .busy       (slew_busy),
        .hold       (hold)
    );

    code_phase #(
        .CHIP_W  (CHIP_W),
        .PRI_LEN (PRI_LEN),
        .ALT_LEN (ALT_LEN)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .tick    (half_tick),
        .hold    (hold),
        .alt     (alt_code),
        .chip    (chip_idx),
        .wrap_ev (wrap_ev),
        .dump    (dump)
    );

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (slew_busy && half_tick) |=> $stable(chip_idx)); // R3

    AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        !half_tick |=> $stable(chip_idx)); // R2

    AST_TIC_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!preset_mode && tic && !slew_busy && !wrap_ev && !wr_en) |=> !slew_busy); // R5

endmodule

// File: tb/code_slew_ctrl_tb.sv
module code_slew_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        half_tick = 1'b1;
    logic        preset_mode = 1'b0;
    logic        alt_code = 1'b0;
    logic        tic = 1'b0;
    logic        wr_en = 1'b0;
    logic [10:0] wr_data = '0;
    logic [9:0]  chip_idx;
    logic        dump;
    logic        slew_busy;

    int cyc = 0;
    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    code_slew_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .half_tick   (half_tick),
        .preset_mode (preset_mode),
        .alt_code    (alt_code),
        .tic         (tic),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .chip_idx    (chip_idx),
        .dump        (dump),
        .slew_busy   (slew_busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic do_reset(input logic alt);
        alt_code = alt;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic next_dump(output int t);
        do @(negedge clk); while (!dump);
        t = cyc;
    endtask

    task automatic host_write(input int v);
        wr_data = 11'(v);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_tic();
        tic = 1'b1;
        @(negedge clk);
        tic = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(chip_idx == 10'd1, "R1 chip", int'(chip_idx), 1);
        check(dump == 1'b0, "R1 dump", int'(dump), 0);
        check(slew_busy == 1'b0, "R1 busy", int'(slew_busy), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_free();
        int a, b, c0;
        half_tick = 1'b0;
        c0 = int'(chip_idx);
        repeat (5) @(negedge clk);
        check(int'(chip_idx) == c0, "R2 hold without tick", int'(chip_idx), c0);
        half_tick = 1'b1;
        repeat (4) @(negedge clk);
        check(int'(chip_idx) == c0 + 2, "R2 advance per two ticks", int'(chip_idx), c0 + 2);
        next_dump(a);
        check(chip_idx == 10'd1, "R2 dump at chip 1", int'(chip_idx), 1);
        next_dump(b);
        check(b - a == 2046, "R2 epoch", b - a, 2046);
    endtask

    task automatic t_update();
        int a, b, c, d, n1, nb;
        next_dump(a);
        host_write(4);
        next_dump(b);
        n1 = 0;
        nb = 0;
        while (chip_idx == 10'd1) begin
            n1++;
            if (slew_busy) nb++;
            @(negedge clk);
        end
        check(n1 == 6, "R3 chip 1 span", n1, 6);
        check(nb == 4, "R10 busy span", nb, 4);
        next_dump(c);
        check(c - b == 2050, "R3 stretched epoch", c - b, 2050);
        next_dump(d);
        check(d - c == 2046, "R7 slew used once", d - c, 2046);
    endtask

    task automatic t_tic_ignored();
        int a, b, c;
        next_dump(a);
        host_write(8);
        repeat (100) @(negedge clk);
        pulse_tic();
        check(slew_busy == 1'b0, "R5 tic ignored in wrap mode", int'(slew_busy), 0);
        next_dump(b);
        check(b - a == 2046, "R5 epoch unaffected by tic", b - a, 2046);
        next_dump(c);
        check(c - b == 2054, "R5 wrap still arms", c - b, 2054);
    endtask

    task automatic t_latest();
        int a, b, c;
        next_dump(a);
        host_write(2);
        repeat (10) @(negedge clk);
        host_write(6);
        next_dump(b);
        next_dump(c);
        check(c - b == 2052, "R6 last write wins", c - b, 2052);
    endtask

    task automatic t_preset();
        int a, b, c;
        preset_mode = 1'b1;
        next_dump(a);
        host_write(3);
        next_dump(b);
        check(b - a == 2046, "R5 wrap ignored in strobe mode", b - a, 2046);
        repeat (50) @(negedge clk);
        pulse_tic();
        check(slew_busy == 1'b1, "R4 busy after tic", int'(slew_busy), 1);
        next_dump(c);
        check(c - b == 2049, "R4 strobe-armed stretch", c - b, 2049);
    endtask

    task automatic t_reload();
        int a, b;
        next_dump(a);
        host_write(10);
        repeat (30) @(negedge clk);
        tic = 1'b1;
        @(negedge clk);
        tic = 1'b0;
        wr_data = 11'd20;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        next_dump(b);
        check(b - a == 2067, "R11 write while busy", b - a, 2067);
        preset_mode = 1'b0;
    endtask

    task automatic t_wrap2047();
        int a, b, c;
        next_dump(a);
        host_write(2047);
        next_dump(b);
        next_dump(c);
        check(c - b == 4093, "R8 value 2047", c - b, 4093);
    endtask

    task automatic t_alt();
        int a, b, c, d;
        do_reset(1'b1);
        next_dump(a);
        next_dump(b);
        check(b - a == 1022, "R9 short code epoch", b - a, 1022);
        host_write(1023);
        next_dump(c);
        next_dump(d);
        check(d - c == 2045, "R9 value 1023", d - c, 2045);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_free();
        t_update();
        t_tic_ignored();
        t_latest();
        t_preset();
        t_reload();
        t_wrap2047();
        t_alt();
        finish_run();
    end

endmodule